// File: doc/BRIEF.md
# History-Selected Two-Bit Branch Predictor

This block guesses the direction of conditional branches. It keeps a table of 16 rows, and each row holds four saturating 2-bit counters. Four low bits of the branch address choose the row. A 2-bit register holds the outcomes of the two branches resolved most recently anywhere in the program, and this register chooses the counter inside the row. Two branches that share a row therefore use different counters when the program reaches them along different recent paths.

A fetch stage presents an address on the lookup channel. In the same cycle it receives the direction guess and a copy of the history value that chose the counter. It keeps that copy with the branch. When the branch resolves, the execute stage sends the address, the stored history copy and the actual outcome on the resolve channel. One counter changes, and the outcome moves into the global history. Both channels use valid/ready. Ready is always high on both channels, so the block never applies back-pressure: a beat is accepted in every cycle where its valid is high. The lookup answer is combinational and qualified by the lookup valid. A resolve beat takes effect at the next rising clock edge.

Top module: `hist_sel_predictor`

## Requirements
- R1: After reset every counter holds 1 (weak not-taken), so every lookup predicts not-taken, and the global history reads 00.
- R2: A lookup predicts taken exactly when the selected counter is 2 or 3.
- R3: The row is given by address bits [3:0], and the higher address bits are ignored. The column is the current global history value (0 to 3).
- R4: A resolve beat changes only the counter at the row of its address and the column of its supplied history. All other counters keep their values.
- R5: An outcome of 1 (taken) raises the counter by one and stops at 3. An outcome of 0 (not-taken) lowers it by one and stops at 0.
- R6: Each resolve beat shifts the history left by one bit and puts the outcome in bit 0, with 1 meaning taken. The value 01 means the older branch was not taken and the newer one was taken.
- R7: `lkp_hist` always shows the history value that chose the counter for the current lookup.
- R8: A resolve beat uses the history it carries to pick the column, even when the live history has changed since the lookup.
- R9: When a lookup and a resolve beat fall in the same cycle, the lookup sees the state before the update. The update becomes visible from the next cycle.
- R10: While `rsv_valid` is low, the resolve address, history and outcome inputs have no effect on any counter or on the history.
- R11: `lkp_ready` and `rsv_ready` are always high, and `lkp_valid_o` follows `lkp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lkp_valid | input | 1 | Lookup request valid |
| lkp_ready | output | 1 | Lookup accepted (always 1) |
| lkp_addr | input | PC_W (8) | Branch address for lookup |
| lkp_valid_o | output | 1 | Lookup answer valid |
| lkp_taken | output | 1 | Predicted direction, 1 = taken |
| lkp_hist | output | HIST_W (2) | History value that chose the counter |
| rsv_valid | input | 1 | Resolve beat valid |
| rsv_ready | output | 1 | Resolve accepted (always 1) |
| rsv_addr | input | PC_W (8) | Address of the resolved branch |
| rsv_hist | input | HIST_W (2) | History copy returned from lookup |
| rsv_taken | input | 1 | Actual outcome, 1 = taken |

## Verification
A lookup and a resolve beat can fall in the same cycle, sometimes on the same counter. The vector table places an update to row 3 next to a lookup of row 3 in the same cycle. Its expected answers show the counter value before the update, and the following entry shows the value after it. A long pseudo-random phase then drives both channels in most cycles, using random and stale history copies. It compares each lookup with a bench model that applies an update only after the answer for that cycle has been judged.

// File: rtl/hsp_pkg.sv
package hsp_pkg;
  localparam int unsigned CTR_W = 2;
  typedef logic [CTR_W-1:0] ctr_t;
  localparam ctr_t CTR_MAX  = ctr_t'((1 << CTR_W) - 1);
  localparam ctr_t CTR_HALF = ctr_t'(1 << (CTR_W - 1));
  localparam ctr_t CTR_INIT = ctr_t'((1 << (CTR_W - 1)) - 1);

  function automatic ctr_t ctr_step(input ctr_t cur, input logic up);
    ctr_t nxt;
    nxt = cur;
    if (up && cur != CTR_MAX) nxt = cur + ctr_t'(1);
    else if (!up && cur != '0) nxt = cur - ctr_t'(1);
    return nxt;
  endfunction
endpackage

// File: rtl/hsp_sat_ctr.sv
module hsp_sat_ctr
  import hsp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic up,
  output ctr_t val
);
  always_ff @(posedge clk) begin
    if (!rst_n) val <= CTR_INIT;
    else if (en) val <= ctr_step(val, up);
  end

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(val));
  p_sat_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && up && val == CTR_MAX) |=> val == CTR_MAX);
  p_sat_lo_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !up && val == '0) |=> val == '0);
  p_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && up && val != CTR_MAX) |=> val == $past(val) + ctr_t'(1));
endmodule

// File: rtl/hsp_table.sv
module hsp_table
  import hsp_pkg::*;
#(
  parameter int unsigned ROW_W  = 4,
  parameter int unsigned HIST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ROW_W-1:0]  rd_row,
  input  logic [HIST_W-1:0] rd_col,
  output ctr_t              rd_val,
  input  logic              we,
  input  logic [ROW_W-1:0]  wr_row,
  input  logic [HIST_W-1:0] wr_col,
  input  logic              wr_up
);
  localparam int unsigned SEL_W = ROW_W + HIST_W;
  localparam int unsigned CELLS = 1 << SEL_W;

  ctr_t            cells [CELLS];
  logic [CELLS-1:0] en_vec;
  logic [SEL_W-1:0] wr_sel;
  logic [SEL_W-1:0] rd_sel;

  assign wr_sel = {wr_row, wr_col};
  assign rd_sel = {rd_row, rd_col};

  for (genvar i = 0; i < CELLS; i++) begin : g_cell
    assign en_vec[i] = we && (wr_sel == SEL_W'(i));
    hsp_sat_ctr u_ctr (
      .clk (clk),
      .rst_n (rst_n),
      .en  (en_vec[i]),
      .up  (wr_up),
      .val (cells[i])
    );
  end

  assign rd_val = cells[rd_sel];

  p_single_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(en_vec));
  p_write_when_asked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !we |-> en_vec == '0);
endmodule

// File: rtl/hsp_ghist.sv
module hsp_ghist #(
  parameter int unsigned HIST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              outcome,
  output logic [HIST_W-1:0] hist
);
  always_ff @(posedge clk) begin
    if (!rst_n) hist <= '0;
    else if (shift_en) hist <= {hist[HIST_W-2:0], outcome};
  end

  p_newest_lsb_r6: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> hist[0] == $past(outcome));
  p_older_moves_r6: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> hist[1] == $past(hist[0]));
  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(hist));
endmodule

// File: rtl/hist_sel_predictor.sv
module hist_sel_predictor
  import hsp_pkg::*;
#(
  parameter int unsigned PC_W   = 8,
  parameter int unsigned ROW_W  = 4,
  parameter int unsigned HIST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lkp_valid,
  output logic              lkp_ready,
  input  logic [PC_W-1:0]   lkp_addr,
  output logic              lkp_valid_o,
  output logic              lkp_taken,
  output logic [HIST_W-1:0] lkp_hist,
  input  logic              rsv_valid,
  output logic              rsv_ready,
  input  logic [PC_W-1:0]   rsv_addr,
  input  logic [HIST_W-1:0] rsv_hist,
  input  logic              rsv_taken
);
  logic [HIST_W-1:0] ghist;
  ctr_t              sel_ctr;

  assign lkp_ready = 1'b1;
  assign rsv_ready = 1'b1;

  hsp_ghist #(.HIST_W(HIST_W)) u_ghist (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (rsv_valid),
    .outcome  (rsv_taken),
    .hist     (ghist)
  );

  hsp_table #(.ROW_W(ROW_W), .HIST_W(HIST_W)) u_table (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_row (lkp_addr[ROW_W-1:0]),
    .rd_col (ghist),
    .rd_val (sel_ctr),
    .we     (rsv_valid),
    .wr_row (rsv_addr[ROW_W-1:0]),
    .wr_col (rsv_hist),
    .wr_up  (rsv_taken)
  );

  assign lkp_valid_o = lkp_valid;
  assign lkp_taken   = (sel_ctr >= CTR_HALF);
  assign lkp_hist    = ghist;

  p_hist_steady_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rsv_valid |=> lkp_hist == $past(lkp_hist));
endmodule

// File: tb/tb_hist_sel_predictor.sv
`timescale 1ns/1ps
module tb_hist_sel_predictor;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lkp_valid = 1'b0;
  logic       lkp_ready;
  logic [7:0] lkp_addr = '0;
  logic       lkp_valid_o;
  logic       lkp_taken;
  logic [1:0] lkp_hist;
  logic       rsv_valid = 1'b0;
  logic       rsv_ready;
  logic [7:0] rsv_addr = '0;
  logic [1:0] rsv_hist = '0;
  logic       rsv_taken = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  hist_sel_predictor dut (
    .clk(clk), .rst_n(rst_n),
    .lkp_valid(lkp_valid), .lkp_ready(lkp_ready), .lkp_addr(lkp_addr),
    .lkp_valid_o(lkp_valid_o), .lkp_taken(lkp_taken), .lkp_hist(lkp_hist),
    .rsv_valid(rsv_valid), .rsv_ready(rsv_ready), .rsv_addr(rsv_addr),
    .rsv_hist(rsv_hist), .rsv_taken(rsv_taken)
  );

  // {rsv_valid, rsv_addr, rsv_hist, rsv_taken, lkp_addr, exp_taken, exp_hist}
  localparam int NV = 15;
  localparam logic [22:0] VEC [NV] = '{
    {1'b0, 8'h00, 2'd0, 1'b0, 8'h03, 1'b0, 2'd0},
    {1'b1, 8'h03, 2'd0, 1'b1, 8'h03, 1'b0, 2'd0},
    {1'b1, 8'h03, 2'd0, 1'b1, 8'h03, 1'b0, 2'd1},
    {1'b0, 8'h00, 2'd0, 1'b0, 8'h03, 1'b0, 2'd3},
    {1'b1, 8'h03, 2'd3, 1'b0, 8'h05, 1'b0, 2'd3},
    {1'b1, 8'h03, 2'd2, 1'b0, 8'h03, 1'b0, 2'd2},
    {1'b0, 8'h00, 2'd0, 1'b0, 8'h03, 1'b1, 2'd0},
    {1'b1, 8'h03, 2'd0, 1'b1, 8'h03, 1'b1, 2'd0},
    {1'b1, 8'h03, 2'd0, 1'b0, 8'h03, 1'b0, 2'd1},
    {1'b0, 8'h00, 2'd0, 1'b0, 8'h03, 1'b0, 2'd2},
    {1'b1, 8'h03, 2'd0, 1'b0, 8'h03, 1'b0, 2'd2},
    {1'b0, 8'h00, 2'd0, 1'b0, 8'h03, 1'b0, 2'd0},
    {1'b1, 8'h23, 2'd0, 1'b1, 8'h13, 1'b0, 2'd0},
    {1'b1, 8'h03, 2'd0, 1'b1, 8'h43, 1'b0, 2'd1},
    {1'b0, 8'h00, 2'd0, 1'b0, 8'h03, 1'b0, 2'd3}
  };

  int ref_ctr [16][4];
  logic [1:0] ref_hist;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    rsv_valid = 1'b0;
    lkp_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    for (int r = 0; r < 16; r++)
      for (int c = 0; c < 4; c++) ref_ctr[r][c] = 1;
    ref_hist = 2'd0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    do_reset();

    // Vector table: R2 R3 R4 R5 R6 R7, same-cycle lookup/update R9
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      rsv_valid = VEC[v][22];
      rsv_addr  = VEC[v][21:14];
      rsv_hist  = VEC[v][13:12];
      rsv_taken = VEC[v][11];
      lkp_addr  = VEC[v][10:3];
      lkp_valid = 1'b1;
      #2;
      check("R2/R9 vector taken", int'(lkp_taken), int'(VEC[v][2]));
      check("R6/R7 vector hist", int'(lkp_hist), int'(VEC[v][1:0]));
    end

    // R11: handshake levels
    #1;
    check("R11 lkp_ready", int'(lkp_ready), 1);
    check("R11 rsv_ready", int'(rsv_ready), 1);
    check("R11 valid follows", int'(lkp_valid_o), 1);
    @(negedge clk);
    rsv_valid = 1'b0;
    lkp_valid = 1'b0;
    #2;
    check("R11 valid low follows", int'(lkp_valid_o), 0);

    // R1: reset state over every row
    do_reset();
    for (int r = 0; r < 16; r++) begin
      @(negedge clk);
      lkp_valid = 1'b1;
      lkp_addr  = 8'(r);
      #2;
      check("R1 reset predicts not-taken", int'(lkp_taken), 0);
      check("R1 reset history", int'(lkp_hist), 0);
    end

    // R10: resolve inputs toggle with valid low; state must not move
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      rsv_valid = 1'b0;
      rsv_addr  = 8'h07;
      rsv_hist  = 2'd0;
      rsv_taken = 1'b1;
      lkp_addr  = 8'h07;
      #2;
      check("R10 idle counter", int'(lkp_taken), 0);
      check("R10 idle history", int'(lkp_hist), 0);
    end

    // Mixed random phase against a bench model: R3 R4 R5 R8 R9
    for (int k = 0; k < 3000; k++) begin
      int r, c;
      @(negedge clk);
      lkp_valid = 1'b1;
      lkp_addr  = 8'($urandom);
      lkp_addr[3:2] = 2'($urandom_range(0, 1));
      rsv_valid = ($urandom_range(0, 3) != 0);
      rsv_addr  = 8'($urandom);
      rsv_addr[3:2] = 2'($urandom_range(0, 1));
      // R8: mostly the live history, sometimes a stale copy
      rsv_hist  = ($urandom_range(0, 2) == 0) ? 2'($urandom) : ref_hist;
      rsv_taken = ($urandom_range(0, 9) < 6);
      #2;
      r = int'(lkp_addr[3:0]);
      check("R3/R4/R9 model taken", int'(lkp_taken), (ref_ctr[r][ref_hist] >= 2) ? 1 : 0);
      check("R6 model history", int'(lkp_hist), int'(ref_hist));
      if (rsv_valid) begin
        r = int'(rsv_addr[3:0]);
        c = int'(rsv_hist);
        if (rsv_taken) begin
          if (ref_ctr[r][c] < 3) ref_ctr[r][c]++;
        end else begin
          if (ref_ctr[r][c] > 0) ref_ctr[r][c]--;
        end
        ref_hist = {ref_hist[0], rsv_taken};
      end
    end

    @(negedge clk);
    rsv_valid = 1'b0;
    lkp_valid = 1'b0;
    done = 1'b1;
    finish_run();
  end
endmodule